// File: doc/BRIEF.md
# ADC Channel Sequencer Controller

This block chooses which analog input of an eight-input converter is sampled in each conversion frame. A serial frame decoder upstream presents the decoded fields of each frame (a write bit, a register select, two sequencing bits, a channel address and a data byte) together with a one-cycle frame strobe. On every strobe the block takes in any write the frame carries and updates its registered channel output. That output names the input converted in the following frame.

Three channel-selection behaviours are supported. In traditional mode the host names every channel explicitly. In consecutive mode the block counts upward from channel 0 to a programmed end channel. In programmed mode it walks the set bits of an 8-bit mask. A guard rejects range-register writes while any sequence is active. A rejected write raises a sticky error flag. An accepted write produces a one-cycle write enable for the range registers, which sit outside this block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode output is 0 (traditional), the channel is 0, range_err and range_we are 0, and the sequence mask is empty. With the mask empty, starting the programmed sequence yields channel 0.
- R2: A control write (reg_sel = 0) whose two sequencing bits are equal (00 or 11) selects traditional mode (mode = 0) and loads the channel address into the channel output. Strobes that carry no write then hold the channel.
- R3: A control write with seq1 = 1 and seq2 = 0 selects consecutive mode (mode = 1). The channel becomes 0, and each following strobe adds 1 until the end channel given by that write's address is reached. The strobe after the end channel returns to 0. An end channel of 0 gives channel 0 on every frame.
- R4: A control write with seq1 = 0 and seq2 = 1 selects programmed mode (mode = 2) and starts at the lowest set bit of the mask. Each following strobe moves to the next higher set bit, wrapping to the lowest one. An all-zero mask gives channel 0.
- R5: A write with reg_sel = 2 loads wr_data into the mask and leaves the mode unchanged. A strobe that carries a mask write advances using the mask held before that write.
- R6: A strobe whose write bit is 0 changes no configuration, and a running sequence moves to its next channel.
- R7: A range write (reg_sel = 1) that arrives while mode is not 0 does not assert range_we. It sets range_err, and the sequence keeps advancing.
- R8: A range write in traditional mode asserts range_we for exactly the one cycle after its strobe.
- R9: range_err stays set until the next control write, which clears it.
- R10: A control write of 00 stops any sequence and returns to traditional mode at the written address. A later 01 write restarts the programmed sequence from its first channel.
- R11: The channel output changes only on a clock edge where frame_stb is 1. Fields presented without the strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per conversion frame |
| wr_en | input | 1 | Frame carries a register write |
| reg_sel | input | 2 | 0 control, 1 range, 2 sequence mask, 3 none |
| seq1 | input | 1 | Sequencing bit 1 of a control write |
| seq2 | input | 1 | Sequencing bit 2 of a control write |
| chan_addr | input | 3 | Channel address of a control write |
| wr_data | input | 8 | Mask value of a mask write |
| chan | output | 3 | Channel for the next conversion |
| mode | output | 2 | 0 traditional, 1 consecutive, 2 programmed |
| range_we | output | 1 | Accepted range-register write pulse |
| range_err | output | 1 | Sticky flag for a rejected range write |

## Verification
Every result is registered exactly once. Channel, mode, mask and error flag therefore all take their new values on the clock edge that samples the strobe, and range_we is high only in the cycle that follows that edge. The bench drives the fields and the strobe on falling edges, lets one rising edge pass, and samples on the next falling edge. For range_we it checks one further falling edge to confirm that the pulse has already ended. The mask-versus-advance ordering and the ignored unstrobed fields are checked at those same sample points.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    typedef enum logic [1:0] {
        MODE_TRAD   = 2'd0,
        MODE_CONSEC = 2'd1,
        MODE_PROG   = 2'd2
    } seq_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RANGE = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ctrl;
        logic rng;
        logic mask;
    } wr_kind_t;

    // Equal bits alias to traditional mode.
    function automatic seq_mode_e decode_mode(input logic s1, input logic s2);
        case ({s1, s2})
            2'b10:   return MODE_CONSEC;
            2'b01:   return MODE_PROG;
            default: return MODE_TRAD;
        endcase
    endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
    import seqctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_kind_t        kind,
    input  logic            seq1,
    input  logic            seq2,
    input  logic [CH_W-1:0] addr,
    input  logic [NCH-1:0]  data,
    output seq_mode_e       mode_q,
    output logic [CH_W-1:0] end_q,
    output logic [NCH-1:0]  mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_TRAD;
            end_q  <= '0;
            mask_q <= '0;
        end else begin
            if (kind.ctrl) begin
                mode_q <= decode_mode(seq1, seq2);
                end_q  <= addr;
            end
            if (kind.mask)
                mask_q <= data;
        end
    end

    // R5: a mask write never moves the mode
    a_r5_mask_keeps_mode: assert property (@(posedge clk) disable iff (rst)
        (kind.mask && !kind.ctrl) |=> $stable(mode_q));
endmodule

// File: rtl/seq_chan_gen.sv
module seq_chan_gen
    import seqctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            ctrl_wr,
    input  logic            mask_wr,
    input  seq_mode_e       new_mode,
    input  logic [CH_W-1:0] addr,
    input  seq_mode_e       mode,
    input  logic [CH_W-1:0] end_ch,
    input  logic [NCH-1:0]  mask,
    output logic [CH_W-1:0] chan_q
);
    // Next set bit strictly after 'from', wrapping; 0 when mask empty.
    function automatic logic [CH_W-1:0] next_set(input logic [NCH-1:0] m,
                                                 input logic [CH_W-1:0] from);
        logic            found;
        logic [CH_W-1:0] res;
        found = 1'b0;
        res   = '0;
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(from) + k) % NCH;
            if (!found && m[idx]) begin
                found = 1'b1;
                res   = CH_W'(idx);
            end
        end
        return res;
    endfunction

    logic [CH_W-1:0] chan_d;

    always_comb begin
        chan_d = chan_q;
        if (ctrl_wr) begin
            case (new_mode)
                MODE_CONSEC: chan_d = '0;
                MODE_PROG:   chan_d = next_set(mask, CH_W'(NCH - 1));
                default:     chan_d = addr;
            endcase
        end else begin
            case (mode)
                MODE_CONSEC: chan_d = (chan_q == end_ch) ? '0 : chan_q + CH_W'(1);
                MODE_PROG:   chan_d = next_set(mask, chan_q);
                default:     chan_d = chan_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            chan_q <= '0;
        else if (frame_stb) chan_q <= chan_d;
    end

    // R11: no strobe, no channel change
    a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(chan_q));
    // R3: consecutive channel never passes the end channel
    a_r3_within_end: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CONSEC) |-> (chan_q <= end_ch));
    // R4: programmed steps land on a set mask bit
    a_r4_on_set_bit: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && !ctrl_wr && !mask_wr && mode == MODE_PROG && mask != '0)
        |=> mask[chan_q]);
endmodule

// File: rtl/seq_range_guard.sv
module seq_range_guard
    import seqctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rng_wr,
    input  logic      ctrl_wr,
    input  seq_mode_e mode,
    output logic      range_we_q,
    output logic      range_err_q
);
    logic busy;
    assign busy = (mode != MODE_TRAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            range_we_q  <= 1'b0;
            range_err_q <= 1'b0;
        end else begin
            range_we_q <= rng_wr && !busy;
            if (ctrl_wr)
                range_err_q <= 1'b0;
            else if (rng_wr && busy)
                range_err_q <= 1'b1;
        end
    end

    // R7: an accepted range write only happens in traditional mode
    a_r7_we_only_trad: assert property (@(posedge clk) disable iff (rst)
        range_we_q |-> (mode == MODE_TRAD));
    // R8: the write pulse lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        range_we_q |=> !range_we_q);
    // R9: error flag is sticky until a control write
    a_r9_sticky_err: assert property (@(posedge clk) disable iff (rst)
        (range_err_q && !ctrl_wr) |=> range_err_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import seqctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            wr_en,
    input  logic [1:0]      reg_sel,
    input  logic            seq1,
    input  logic            seq2,
    input  logic [CH_W-1:0] chan_addr,
    input  logic [NCH-1:0]  wr_data,
    output logic [CH_W-1:0] chan,
    output logic [1:0]      mode,
    output logic            range_we,
    output logic            range_err
);
    wr_kind_t        kind;
    seq_mode_e       mode_q;
    logic [CH_W-1:0] end_q;
    logic [NCH-1:0]  mask_q;

    always_comb begin
        kind.ctrl = frame_stb && wr_en && (reg_sel == SEL_CTRL);
        kind.rng  = frame_stb && wr_en && (reg_sel == SEL_RANGE);
        kind.mask = frame_stb && wr_en && (reg_sel == SEL_MASK);
    end

    seq_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .kind   (kind),
        .seq1   (seq1),
        .seq2   (seq2),
        .addr   (chan_addr),
        .data   (wr_data),
        .mode_q (mode_q),
        .end_q  (end_q),
        .mask_q (mask_q)
    );

    seq_chan_gen #(.NCH(NCH)) u_chan (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .ctrl_wr   (kind.ctrl),
        .mask_wr   (kind.mask),
        .new_mode  (decode_mode(seq1, seq2)),
        .addr      (chan_addr),
        .mode      (mode_q),
        .end_ch    (end_q),
        .mask      (mask_q),
        .chan_q    (chan)
    );

    seq_range_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .rng_wr      (kind.rng),
        .ctrl_wr     (kind.ctrl),
        .mode        (mode_q),
        .range_we_q  (range_we),
        .range_err_q (range_err)
    );

    assign mode = mode_q;

    // R2: equal sequencing bits always land in traditional mode at the address
    a_r2_trad_load: assert property (@(posedge clk) disable iff (rst)
        (kind.ctrl && (seq1 == seq2)) |=> (mode == 2'd0 && chan == $past(chan_addr)));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_stb = 1'b0, wr_en = 1'b0, seq1 = 1'b0, seq2 = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic [2:0] chan_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] chan;
    logic [1:0] mode;
    logic       range_we, range_err;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .wr_en(wr_en),
        .reg_sel(reg_sel), .seq1(seq1), .seq2(seq2), .chan_addr(chan_addr),
        .wr_data(wr_data), .chan(chan), .mode(mode),
        .range_we(range_we), .range_err(range_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One frame: drive on falling edge, sample at the following falling edge.
    task automatic frame(input bit stb, input bit we, input int sel,
                         input bit s1, input bit s2, input int addr, input int data);
        @(negedge clk);
        frame_stb = stb; wr_en = we; reg_sel = 2'(sel);
        seq1 = s1; seq2 = s2; chan_addr = 3'(addr); wr_data = 8'(data);
        @(negedge clk);
        frame_stb = 1'b0; wr_en = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic ctrl(input bit s1, input bit s2, input int addr);
        frame(1, 1, 0, s1, s2, addr, 0);
    endtask

    task automatic step();
        frame(1, 0, 3, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 chan", chan, 0);
        chk("R1 mode", mode, 0);
        chk("R1 err", range_err, 0);
        chk("R1 we", range_we, 0);
        ctrl(0, 1, 0);
        chk("R1 empty mask start", chan, 0);
        chk("R4 mode prog", mode, 2);
        step();
        chk("R4 empty mask step", chan, 0);
        ctrl(0, 0, 0);
    endtask

    task automatic t_trad();
        ctrl(0, 0, 5);
        chk("R2 load 00", chan, 5);
        chk("R2 mode", mode, 0);
        step();
        chk("R2 hold", chan, 5);
        ctrl(1, 1, 3);
        chk("R2 load 11", chan, 3);
        chk("R2 mode 11", mode, 0);
        frame(0, 1, 0, 1, 0, 6, 0);
        chk("R11 unstrobed ignored", chan, 3);
        chk("R11 mode kept", mode, 0);
        step();
        chk("R11 not latched", chan, 3);
    endtask

    task automatic t_consec();
        int exp_seq[5] = '{1, 2, 3, 0, 1};
        ctrl(1, 0, 3);
        chk("R3 start", chan, 0);
        chk("R3 mode", mode, 1);
        foreach (exp_seq[i]) begin
            step();
            chk("R3 advance", chan, exp_seq[i]);
        end
        ctrl(1, 0, 0);
        chk("R3 end0 start", chan, 0);
        step();
        chk("R3 end0 stay", chan, 0);
    endtask

    task automatic t_prog();
        int exp_seq[4] = '{5, 7, 2, 5};
        frame(1, 1, 2, 0, 0, 0, 8'b1010_0100);
        chk("R5 mode kept", mode, 1);
        ctrl(0, 1, 0);
        chk("R4 first bit", chan, 2);
        chk("R4 mode", mode, 2);
        foreach (exp_seq[i]) begin
            step();
            chk("R6 R4 walk", chan, exp_seq[i]);
        end
        chk("R6 mode kept", mode, 2);
        frame(1, 1, 2, 0, 0, 0, 8'b0000_0011);
        chk("R5 old mask used", chan, 7);
        step();
        chk("R5 new mask wrap", chan, 0);
        step();
        chk("R4 next", chan, 1);
        step();
        chk("R4 wrap", chan, 0);
    endtask

    task automatic t_range();
        frame(1, 1, 1, 0, 0, 0, 0);
        chk("R7 no we", range_we, 0);
        chk("R7 err set", range_err, 1);
        chk("R7 keeps stepping", chan, 1);
        step();
        chk("R9 sticky", range_err, 1);
        chk("R7 still stepping", chan, 0);
        ctrl(0, 0, 4);
        chk("R10 stop mode", mode, 0);
        chk("R10 stop chan", chan, 4);
        chk("R9 cleared", range_err, 0);
        frame(1, 1, 1, 0, 0, 0, 0);
        chk("R8 we pulse", range_we, 1);
        chk("R8 no err", range_err, 0);
        @(negedge clk);
        chk("R8 pulse ends", range_we, 0);
        ctrl(0, 1, 0);
        chk("R10 restart first", chan, 0);
        chk("R10 restart mode", mode, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_trad();
        t_consec();
        t_prog();
        t_range();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule